// File: doc/BRIEF.md
# Line Latch and Reference Group Router

This block is the digital back end of a column driver for an active-matrix display. The front end fills a line buffer of one 6-bit gray code per column. A strobe then marks the end of each horizontal line. On the strobe's rising edge the whole buffer is copied into an output latch. The copy is optionally bit-inverted as it goes in, and the polarity and invert settings are captured at the same moment. On the strobe's falling edge the outputs are released to the drivers.

Each column output gives the latched code and the reference group it must use. Neighbouring columns always use opposite groups, and the captured polarity decides which group the first column takes. Each output also gives a two-bit segment number and the offset inside that segment. A resistor-string converter needs these to pick its tap. The four segments cover 8, 24, 24 and 8 codes. A low-power input is passed on as a registered bias-disable flag for the output amplifiers.

The strobe, polarity, invert and low-power inputs are sampled on the block clock. One strobe pulse is expected per line.

Top module: `lcd_line_latch`

## Requirements
- R1: A rising edge of `strobe`, seen on a clock edge where `strobe` is 1 and was 0 on the previous edge, loads every column's code from `line_buf` (column i at bits [6i+5:6i]). The new codes appear on `code_out` after that clock edge.
- R2: Between strobe rising edges, `code_out` holds its value whatever `line_buf`, `pol` and `inv` do.
- R3: When `inv` is 1 on the loading edge, each code is stored bit-inverted (code XOR 0x3F). When `inv` is 0, the code is stored unchanged.
- R4: `pol` is captured on the loading edge. With a captured 0, columns with even index (0, 2, ...) get `grp_sel`=0 (upper group) and columns with odd index get `grp_sel`=1 (lower group).
- R5: With a captured `pol` of 1, the group assignment of R4 is swapped for every column.
- R6: `out_en` goes to 0 on the loading edge and goes to 1 on the clock edge that sees the strobe fall (1 before, 0 now). It then stays 1 until the next loading edge.
- R7: `seg_idx` for a column is 0 for codes 0x00–0x07, 1 for 0x08–0x1F, 2 for 0x20–0x37 and 3 for 0x38–0x3F. It is packed 2 bits per column at [2i+1:2i].
- R8: `seg_off` for a column equals the code minus its segment base (0x00, 0x08, 0x20 or 0x38). It is packed 5 bits per column at [5i+4:5i].
- R9: `bias_off` equals `low_pwr` delayed by one clock.
- R10: During synchronous reset (`rst_n`=0), every code clears to 0, `out_en` and `bias_off` clear to 0, and the captured polarity clears to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Line strobe; rise loads, fall enables |
| pol | input | 1 | Polarity select, captured on load |
| inv | input | 1 | Data inversion, applied on load |
| low_pwr | input | 1 | Low-power request for output amplifiers |
| line_buf | input | NUM_CH*6 | Sampled line of 6-bit codes |
| code_out | output | NUM_CH*6 | Latched codes |
| grp_sel | output | NUM_CH | Reference group per column (0 upper, 1 lower) |
| seg_idx | output | NUM_CH*2 | Converter segment per column |
| seg_off | output | NUM_CH*5 | Offset inside segment per column |
| out_en | output | 1 | Output drive enable |
| bias_off | output | 1 | Amplifier bias disable |

## Verification
Two actions can land on the same clock edge: the enable drop and the reload of the latch. Both happen when a new strobe rise arrives while the outputs are still driving. The bench provokes this by raising the strobe straight after a driving period. On that same edge it also changes the polarity, the invert setting and the line data. After that edge it expects `out_en` low, codes from the new line, and group selects that follow the new polarity. The following strobe fall must then restore the enable without disturbing the codes.

// File: rtl/lcd_line_pkg.sv
// Package: shared widths and the segment type for the line latch.
// Assumes 6-bit gray codes and a four-segment resistor string.
package lcd_line_pkg;
    localparam int CODE_W = 6;
    localparam int SEG_W  = 2;
    localparam int OFF_W  = 5;

    typedef enum logic [SEG_W-1:0] {
        SEG_LOW   = 2'd0,
        SEG_MIDLO = 2'd1,
        SEG_MIDHI = 2'd2,
        SEG_TOP   = 2'd3
    } seg_t;

    localparam logic [CODE_W-1:0] BASE_MIDLO = 6'h08;
    localparam logic [CODE_W-1:0] BASE_MIDHI = 6'h20;
    localparam logic [CODE_W-1:0] BASE_TOP   = 6'h38;
endpackage

// File: rtl/strobe_ctrl.sv
// Module: strobe_ctrl
// Finds the strobe edges on the block clock. Captures polarity on the
// loading edge, drives the output enable and registers the bias flag.
// Assumes the strobe is already synchronous to clk.
module strobe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pol,
    input  logic low_pwr,
    output logic load_now,
    output logic pol_q,
    output logic out_en,
    output logic bias_off
);
    logic strobe_q;
    logic fall_now;

    // Edge detection against the previous strobe sample.
    always_comb begin
        load_now = strobe & ~strobe_q;
        fall_now = ~strobe & strobe_q;
    end

    // Strobe history register.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Polarity capture on the loading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= 1'b0;
        else if (load_now) pol_q <= pol;
    end

    // Enable: cleared on load, set on strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_en <= 1'b0;
        else if (load_now) out_en <= 1'b0;
        else if (fall_now) out_en <= 1'b1;
    end

    // Registered bias-disable request.
    always_ff @(posedge clk) begin
        if (!rst_n) bias_off <= 1'b0;
        else        bias_off <= low_pwr;
    end
endmodule

// File: rtl/line_latch.sv
// Module: line_latch
// Holds one line of codes. On load it copies the buffer, inverting each
// code if asked. Assumes load is a single-cycle pulse.
module line_latch
    import lcd_line_pkg::*;
#(
    parameter int NUM_CH = 384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     inv,
    input  logic [NUM_CH*CODE_W-1:0] din,
    output logic [NUM_CH*CODE_W-1:0] dout
);
    localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_col
        logic [CODE_W-1:0] code_q;
        logic [CODE_W-1:0] code_in;

        // Optional inversion at transfer time.
        always_comb code_in = din[ch*CODE_W +: CODE_W] ^ (inv ? ALL_ONES : '0);

        // Per-column storage register.
        always_ff @(posedge clk) begin
            if (!rst_n)    code_q <= '0;
            else if (load) code_q <= code_in;
        end

        assign dout[ch*CODE_W +: CODE_W] = code_q;
    end
endmodule

// File: rtl/seg_decode.sv
// Module: seg_decode
// Maps one 6-bit code to a segment number and an offset from the
// segment base. Purely combinational.
module seg_decode
    import lcd_line_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output seg_t              seg,
    output logic [OFF_W-1:0]  off
);
    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] diff;

    // Segment choice from the upper code bits.
    always_comb begin
        if (code[5:3] == 3'b000) begin
            seg  = SEG_LOW;
            base = '0;
        end else if (!code[5]) begin
            seg  = SEG_MIDLO;
            base = BASE_MIDLO;
        end else if (code[5:3] != 3'b111) begin
            seg  = SEG_MIDHI;
            base = BASE_MIDHI;
        end else begin
            seg  = SEG_TOP;
            base = BASE_TOP;
        end
    end

    // Offset within the chosen segment.
    always_comb begin
        diff = code - base;
        off  = diff[OFF_W-1:0];
    end
endmodule

// File: rtl/lcd_line_latch.sv
// Module: lcd_line_latch (top)
// Line latch with inversion, alternating reference-group routing and
// segment decode for a resistor-string converter. Assumes one strobe
// pulse per line, synchronous to clk.
module lcd_line_latch
    import lcd_line_pkg::*;
#(
    parameter int NUM_CH = 384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic                     pol,
    input  logic                     inv,
    input  logic                     low_pwr,
    input  logic [NUM_CH*CODE_W-1:0] line_buf,
    output logic [NUM_CH*CODE_W-1:0] code_out,
    output logic [NUM_CH-1:0]        grp_sel,
    output logic [NUM_CH*SEG_W-1:0]  seg_idx,
    output logic [NUM_CH*OFF_W-1:0]  seg_off,
    output logic                     out_en,
    output logic                     bias_off
);
    logic load_now;
    logic pol_q;

    strobe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .pol      (pol),
        .low_pwr  (low_pwr),
        .load_now (load_now),
        .pol_q    (pol_q),
        .out_en   (out_en),
        .bias_off (bias_off)
    );

    line_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_now),
        .inv   (inv),
        .din   (line_buf),
        .dout  (code_out)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_route
        localparam logic ODD_COL = (ch % 2) == 1;
        seg_t seg_c;

        // Neighbouring columns alternate; polarity swaps the pattern.
        assign grp_sel[ch] = pol_q ^ ODD_COL;

        seg_decode u_dec (
            .code (code_out[ch*CODE_W +: CODE_W]),
            .seg  (seg_c),
            .off  (seg_off[ch*OFF_W +: OFF_W])
        );

        assign seg_idx[ch*SEG_W +: SEG_W] = seg_c;
    end
endmodule

// File: rtl/lcd_line_latch_chk.sv
// Module: lcd_line_latch_chk
// Checker bound to lcd_line_latch; watches the ports only.
module lcd_line_latch_chk
    import lcd_line_pkg::*;
#(
    parameter int NUM_CH = 384
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     strobe,
    input logic                     inv,
    input logic                     low_pwr,
    input logic [NUM_CH*CODE_W-1:0] line_buf,
    input logic [NUM_CH*CODE_W-1:0] code_out,
    input logic [NUM_CH-1:0]        grp_sel,
    input logic [NUM_CH*OFF_W-1:0]  seg_off,
    input logic [NUM_CH*SEG_W-1:0]  seg_idx,
    input logic                     out_en,
    input logic                     bias_off
);
    logic prev_stb;
    logic rise_c;
    logic fall_c;

    // Checker-side strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_stb <= 1'b0;
        else        prev_stb <= strobe;
    end

    always_comb begin
        rise_c = strobe & ~prev_stb;
        fall_c = ~strobe & prev_stb;
    end

    AST_LOAD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c |=> code_out == ($past(inv) ? ~$past(line_buf) : $past(line_buf))); // R1
    AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_c |=> $stable(code_out)); // R2
    AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c |=> !out_en); // R6
    AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_c |=> out_en); // R6
    AST_GRP_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        grp_sel[0] != grp_sel[1]); // R4
    AST_BIAS_DLY: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c || !rise_c |=> bias_off == $past(low_pwr)); // R9
    AST_TOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx[1:0] == 2'd3 |-> seg_off[4:3] == 2'b00); // R8
endmodule

bind lcd_line_latch lcd_line_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inv      (inv),
    .low_pwr  (low_pwr),
    .line_buf (line_buf),
    .code_out (code_out),
    .grp_sel  (grp_sel),
    .seg_off  (seg_off),
    .seg_idx  (seg_idx),
    .out_en   (out_en),
    .bias_off (bias_off)
);

// File: tb/tb_lcd_line_latch.sv
module tb_lcd_line_latch;
    localparam int NCH = 384;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic              pol = 1'b0;
    logic              inv = 1'b0;
    logic              low_pwr = 1'b0;
    logic [NCH*6-1:0]  line_buf = '0;
    logic [NCH*6-1:0]  code_out;
    logic [NCH-1:0]    grp_sel;
    logic [NCH*2-1:0]  seg_idx;
    logic [NCH*5-1:0]  seg_off;
    logic              out_en;
    logic              bias_off;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NCH*6-1:0] ref_line;

    lcd_line_latch #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pol(pol), .inv(inv),
        .low_pwr(low_pwr), .line_buf(line_buf), .code_out(code_out),
        .grp_sel(grp_sel), .seg_idx(seg_idx), .seg_off(seg_off),
        .out_en(out_en), .bias_off(bias_off)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pat(int seed, int i);
        return 6'((i * seed + seed * 3) % 64);
    endfunction

    function automatic logic [NCH*6-1:0] make_line(int seed);
        logic [NCH*6-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*6 +: 6] = (seed == 0) ? 6'(i % 64) : pat(seed, i);
        return v;
    endfunction

    // Compare all codes against an expected line; one check.
    task automatic chk_codes(input logic [NCH*6-1:0] exp, input string req);
        int bad = -1;
        for (int i = 0; i < NCH; i++)
            if (code_out[i*6 +: 6] !== exp[i*6 +: 6] && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(code_out[bad*6 +: 6]), int'(exp[bad*6 +: 6]));
    endtask

    task automatic chk_grp(input logic p, input string req);
        int bad = -1;
        for (int i = 0; i < NCH; i++)
            if (grp_sel[i] !== (p ^ ((i % 2) == 1)) && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, int'(grp_sel[bad]), int'(p ^ ((bad % 2) == 1)));
    endtask

    // Strobe pulse: rise, check load, fall, check enable.
    task automatic pulse(input logic [NCH*6-1:0] data, input logic p, input logic iv);
        @(negedge clk);
        line_buf = data; pol = p; inv = iv; strobe = 1'b1;
        @(negedge clk);
        chk(out_en === 1'b0, "R6 enable low after load", int'(out_en), 0);
        strobe = 1'b0;
        @(negedge clk);
        chk(out_en === 1'b1, "R6 enable high after fall", int'(out_en), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_codes('0, "R10 codes zero in reset");
        chk(out_en === 1'b0 && bias_off === 1'b0, "R10 flags zero", int'({out_en, bias_off}), 0);
        chk_grp(1'b0, "R10 polarity cleared");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_plain();
        ref_line = make_line(5);
        pulse(ref_line, 1'b0, 1'b0);
        chk_codes(ref_line, "R1 plain load");
        chk_grp(1'b0, "R4 pol low routing");
    endtask

    task automatic t_invert();
        ref_line = make_line(7);
        pulse(ref_line, 1'b1, 1'b1);
        chk_codes(~ref_line, "R3 inverted load");
        chk_grp(1'b1, "R5 pol high routing");
    endtask

    task automatic t_hold();
        logic [NCH*6-1:0] kept;
        kept = code_out;
        @(negedge clk);
        line_buf = make_line(11); pol = 1'b0; inv = 1'b0;
        repeat (4) @(negedge clk);
        chk_codes(kept, "R2 codes held");
        chk_grp(1'b1, "R2 polarity held");
        chk(out_en === 1'b1, "R6 enable stays", int'(out_en), 1);
    endtask

    task automatic t_segments();
        int bad = -1;
        int eseg, eoff, c;
        ref_line = make_line(0);
        pulse(ref_line, 1'b0, 1'b0);
        for (int i = 0; i < 64; i++) begin
            c = i;
            eseg = (c < 8) ? 0 : (c < 32) ? 1 : (c < 56) ? 2 : 3;
            if (seg_idx[i*2 +: 2] !== 2'(eseg) && bad < 0) bad = i;
        end
        chk(bad < 0, "R7 segment map", bad, -1);
        bad = -1;
        for (int i = 0; i < NCH; i++) begin
            c = i % 64;
            eoff = (c < 8) ? c : (c < 32) ? c - 8 : (c < 56) ? c - 32 : c - 56;
            if (seg_off[i*5 +: 5] !== 5'(eoff) && bad < 0) bad = i;
        end
        chk(bad < 0, "R8 offsets", bad, -1);
        chk(seg_idx[7*2 +: 2] === 2'd0 && seg_idx[8*2 +: 2] === 2'd1 &&
            seg_idx[31*2 +: 2] === 2'd1 && seg_idx[32*2 +: 2] === 2'd2 &&
            seg_idx[55*2 +: 2] === 2'd2 && seg_idx[56*2 +: 2] === 2'd3,
            "R7 breakpoints", int'(seg_idx[15:0]), 0);
        chk(seg_off[63*5 +: 5] === 5'd7 && seg_off[31*5 +: 5] === 5'd23,
            "R8 segment ends", int'(seg_off[63*5 +: 5]), 7);
    endtask

    task automatic t_bias();
        @(negedge clk);
        low_pwr = 1'b1;
        @(negedge clk);
        chk(bias_off === 1'b1, "R9 bias set", int'(bias_off), 1);
        low_pwr = 1'b0;
        @(negedge clk);
        chk(bias_off === 1'b0, "R9 bias cleared", int'(bias_off), 0);
    endtask

    // Reload while driving: enable drop and new pol/inv on one edge.
    task automatic t_reload();
        ref_line = make_line(13);
        pulse(make_line(3), 1'b1, 1'b0);
        pulse(ref_line, 1'b0, 1'b1);
        chk_codes(~ref_line, "R3 reload inverted");
        chk_grp(1'b0, "R4 reload pol low");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_plain();
                t_invert();
                t_hold();
                t_segments();
                t_bias();
                t_reload();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule